// File: doc/BRIEF.md
# Program Counter with Return Stack

This block is the address-generation path of a small instruction sequencer. It keeps a 14-bit program counter that names the instruction now executing. On every clock edge the counter reloads from a next-address multiplexer. The multiplexer chooses among the incremented counter, a branch target supplied by the decoder, the top of a return stack, and an external address bus that a register-indirect jump drives. Instruction decode, condition evaluation and interrupt arbitration happen outside the block. They reach it as a 3-bit next-address command plus a target address.

A 16-entry return stack sits beside the counter. It is pushed automatically by subroutine calls, by loop entry and by interrupts, and it is popped by returns and by an explicit discard command. An interrupt saves the current counter value instead of counter+1, so the aborted instruction is fetched again after the service routine returns. A side port lets software read the top entry while popping it, or write a new top entry by pushing it. Overflow and underflow are caught and kept in sticky flags.

Top module: `pcs_top`

## Requirements
- R1: A synchronous active-high reset sets pc_o to 0, depth_o to 0, ovf_o and udf_o to 0, and tos_o to 0.
- R2: With cmd_i = 0 (sequential), pc_o becomes pc_o+1 at the next edge, and 0x3FFF wraps to 0.
- R3: cmd_i = 1 (jump) loads pc_o from target_i. cmd_i = 3 (indirect) loads pc_o from bus_addr_i.
- R4: cmd_i = 4 (call) loads pc_o from target_i and pushes the old pc_o+1.
- R5: cmd_i = 5 (loop entry) advances pc_o by 1 and pushes the old pc_o+1.
- R6: cmd_i = 6 (interrupt) loads pc_o from target_i (the vector) and pushes the old pc_o unchanged.
- R7: cmd_i = 2 (return) loads pc_o from the top entry and pops it. cmd_i = 7 (discard) advances pc_o by 1 and pops the top entry without using it.
- R8: tos_o always shows the top entry, or 0 when the stack is empty. tos_rd_i pops the top entry and tos_wr_i pushes tos_wdata_i. A side read is ignored while the command pops (codes 2 and 7). A side write is ignored while the command pushes (codes 4, 5 and 6).
- R9: A push at depth 16 with no pop in the same cycle leaves the stack and depth_o unchanged and sets ovf_o. ovf_o stays set until reset.
- R10: A pop on an empty stack leaves depth_o at 0, supplies the value 0 (so a return goes to address 0) and sets udf_o. udf_o stays set until reset.
- R11: When a pop and a push fall in the same cycle, the pop is applied first and then the push. On a non-empty stack this replaces the top and keeps the depth, even when the stack is full. On an empty stack the depth becomes 1 and udf_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Next-address command (codes in R2 to R7) |
| target_i | input | 14 | Branch, call or interrupt-vector address |
| bus_addr_i | input | 14 | External address bus for indirect jumps |
| tos_rd_i | input | 1 | Side port: pop the top entry |
| tos_wr_i | input | 1 | Side port: push tos_wdata_i |
| tos_wdata_i | input | 14 | Side port write value |
| pc_o | output | 14 | Program counter |
| tos_o | output | 14 | Current top entry of the stack (0 when empty) |
| depth_o | output | 5 | Number of entries held (0 to 16) |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
Every result lands one edge after its command: pc_o, depth_o and both flags are registers loaded at that edge, and tos_o is decoded from registered state, so it settles in the same cycle. The bench drives inputs on the falling edge and checks every result one time unit after the next rising edge. There is one exception. The value a side read returns is tos_o before the pop takes effect, so that check samples just before the rising edge that applies the pop.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    NA_SEQ  = 3'd0,
    NA_JUMP = 3'd1,
    NA_RET  = 3'd2,
    NA_IND  = 3'd3,
    NA_CALL = 3'd4,
    NA_LOOP = 3'd5,
    NA_IRQ  = 3'd6,
    NA_POP  = 3'd7
  } na_cmd_e;

endpackage

// File: rtl/pcs_incr.sv
module pcs_incr #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] inc_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  // modulo-2^AW increment, the top address wraps to zero
  assign inc_o = pc_i + ONE;

endmodule

// File: rtl/pcs_next_mux.sv
module pcs_next_mux
  import pcs_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] pc_inc_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [AW-1:0] top_i,
  input  logic          side_rd_i,
  input  logic          side_wr_i,
  input  logic [AW-1:0] side_wdata_i,
  output logic [AW-1:0] nxt_pc_o,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] push_data_o
);

  logic          cmd_push;
  logic          cmd_pop;
  logic [AW-1:0] cmd_data;
  na_cmd_e       cmd;

  assign cmd = na_cmd_e'(cmd_i);

  always_comb begin
    nxt_pc_o = pc_inc_i;
    cmd_push = 1'b0;
    cmd_pop  = 1'b0;
    cmd_data = pc_inc_i;
    unique case (cmd)
      NA_SEQ:  nxt_pc_o = pc_inc_i;
      NA_JUMP: nxt_pc_o = target_i;
      NA_RET: begin
        nxt_pc_o = top_i;
        cmd_pop  = 1'b1;
      end
      NA_IND:  nxt_pc_o = bus_addr_i;
      NA_CALL: begin
        nxt_pc_o = target_i;
        cmd_push = 1'b1;
      end
      NA_LOOP: begin
        nxt_pc_o = pc_inc_i;
        cmd_push = 1'b1;
      end
      NA_IRQ: begin
        nxt_pc_o = target_i;
        cmd_push = 1'b1;
        cmd_data = pc_i;
      end
      NA_POP: begin
        nxt_pc_o = pc_inc_i;
        cmd_pop  = 1'b1;
      end
      default: nxt_pc_o = pc_inc_i;
    endcase
  end

  // the command owns the stack; the side port fills in only the free direction
  assign pop_o       = cmd_pop | side_rd_i;
  assign push_o      = cmd_push | side_wr_i;
  assign push_data_o = cmd_push ? cmd_data : side_wdata_i;

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int AW    = 14,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [AW-1:0]              wdata_i,
  output logic [AW-1:0]              top_o,
  output logic [$clog2(DEPTH):0]     depth_o,
  output logic                       ovf_o,
  output logic                       udf_o
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] ONEV  = CW'(1);

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_m1;
  logic [CW-1:0] base;
  logic          empty;
  logic          do_wr;
  logic          ovf_q;
  logic          udf_q;

  assign empty  = (cnt_q == '0);
  assign cnt_m1 = cnt_q - ONEV;
  // pop first: the slot a same-cycle push lands in
  assign base   = (pop_i && !empty) ? cnt_m1 : cnt_q;
  assign do_wr  = push_i && (base != FULLV);

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[base[PW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (pop_i && empty)   udf_q <= 1'b1;
      if (push_i && !do_wr) ovf_q <= 1'b1;
      cnt_q <= do_wr ? base + ONEV : base;
    end
  end

  assign top_o   = empty ? '0 : mem[cnt_m1[PW-1:0]];
  assign depth_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;

endmodule

// File: rtl/pcs_top.sv
module pcs_top #(
  parameter int AW    = 14,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             cmd_i,
  input  logic [AW-1:0]          target_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic                   tos_rd_i,
  input  logic                   tos_wr_i,
  input  logic [AW-1:0]          tos_wdata_i,
  output logic [AW-1:0]          pc_o,
  output logic [AW-1:0]          tos_o,
  output logic [$clog2(DEPTH):0] depth_o,
  output logic                   ovf_o,
  output logic                   udf_o
);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] nxt_pc;
  logic [AW-1:0] top;
  logic [AW-1:0] push_data;
  logic          push;
  logic          pop;
  logic          side_rd;
  logic          side_wr;

  // a side access is dropped when the command already uses that direction
  assign side_rd = tos_rd_i & ~((cmd_i == 3'd2) | (cmd_i == 3'd7));
  assign side_wr = tos_wr_i & ~((cmd_i == 3'd4) | (cmd_i == 3'd5) | (cmd_i == 3'd6));

  pcs_incr #(.AW(AW)) u_incr (
    .pc_i  (pc_q),
    .inc_o (pc_inc)
  );

  pcs_next_mux #(.AW(AW)) u_mux (
    .cmd_i        (cmd_i),
    .pc_i         (pc_q),
    .pc_inc_i     (pc_inc),
    .target_i     (target_i),
    .bus_addr_i   (bus_addr_i),
    .top_i        (top),
    .side_rd_i    (side_rd),
    .side_wr_i    (side_wr),
    .side_wdata_i (tos_wdata_i),
    .nxt_pc_o     (nxt_pc),
    .push_o       (push),
    .pop_o        (pop),
    .push_data_o  (push_data)
  );

  pcs_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (push_data),
    .top_o   (top),
    .depth_o (depth_o),
    .ovf_o   (ovf_o),
    .udf_o   (udf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= nxt_pc;
  end

  assign pc_o  = pc_q;
  assign tos_o = top;

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int AW    = 14,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2:0]             cmd_i,
  input logic [AW-1:0]          target_i,
  input logic [AW-1:0]          bus_addr_i,
  input logic                   tos_rd_i,
  input logic                   tos_wr_i,
  input logic [AW-1:0]          pc_o,
  input logic [AW-1:0]          tos_o,
  input logic [$clog2(DEPTH):0] depth_o,
  input logic                   ovf_o,
  input logic                   udf_o
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_o == '0 && depth_o == '0 && !ovf_o && !udf_o));

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0 && !tos_rd_i && !tos_wr_i) |=> (pc_o == AW'($past(pc_o) + 1'b1)));

  a_r3_indirect: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd3) |=> (pc_o == $past(bus_addr_i)));

  a_r4_call_push: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd4 && !tos_rd_i && depth_o != FULLV) |=>
      (pc_o == $past(target_i) && tos_o == AW'($past(pc_o) + 1'b1)
       && depth_o == $past(depth_o) + 1'b1));

  a_r6_irq_push: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd6 && !tos_rd_i && depth_o != FULLV) |=> (tos_o == $past(pc_o)));

  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd2 && !tos_wr_i) |=> (pc_o == $past(tos_o)));

  a_r9_no_overflow_depth: assert property (@(posedge clk) disable iff (rst)
    depth_o <= FULLV);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  a_r10_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    udf_o |=> udf_o);

  a_r8_empty_top_zero: assert property (@(posedge clk) disable iff (rst)
    (depth_o == '0) |-> (tos_o == '0));

endmodule

bind pcs_top pcs_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_i      (cmd_i),
  .target_i   (target_i),
  .bus_addr_i (bus_addr_i),
  .tos_rd_i   (tos_rd_i),
  .tos_wr_i   (tos_wr_i),
  .pc_o       (pc_o),
  .tos_o      (tos_o),
  .depth_o    (depth_o),
  .ovf_o      (ovf_o),
  .udf_o      (udf_o)
);

// File: tb/sim_pcs_top.sv
`timescale 1ns/1ps
module sim_pcs_top;

  localparam int AW = 14;
  localparam int DEPTH = 16;
  localparam int NV = 14;
  localparam int VW = 3 + 14 + 14 + 1 + 1 + 14 + 14 + 5 + 14;

  // {cmd, target, bus, rd, wr, wdata, exp_pc, exp_depth, exp_tos}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0001, 5'd0, 14'h0000}, // R2
    {3'd1, 14'h0100, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0100, 5'd0, 14'h0000}, // R3 jump
    {3'd4, 14'h0200, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0200, 5'd1, 14'h0101}, // R4
    {3'd0, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0201, 5'd1, 14'h0101}, // R2
    {3'd5, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0202, 5'd2, 14'h0202}, // R5
    {3'd6, 14'h3F00, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h3F00, 5'd3, 14'h0202}, // R6
    {3'd2, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0202, 5'd2, 14'h0202}, // R7 ret
    {3'd7, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0203, 5'd1, 14'h0101}, // R7 discard
    {3'd3, 14'h0000, 14'h1234, 1'b0, 1'b0, 14'h0000, 14'h1234, 5'd1, 14'h0101}, // R3 indirect
    {3'd2, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 14'h0101, 5'd0, 14'h0000}, // R7 ret
    {3'd0, 14'h0000, 14'h0000, 1'b0, 1'b1, 14'h0ABC, 14'h0102, 5'd1, 14'h0ABC}, // R8 write
    {3'd4, 14'h0050, 14'h0000, 1'b0, 1'b1, 14'h0777, 14'h0050, 5'd2, 14'h0103}, // R8 wr ignored
    {3'd1, 14'h0060, 14'h0000, 1'b1, 1'b0, 14'h0000, 14'h0060, 5'd1, 14'h0ABC}, // R8 read
    {3'd2, 14'h0000, 14'h0000, 1'b1, 1'b0, 14'h0000, 14'h0ABC, 5'd0, 14'h0000}  // R8 rd ignored
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cmd_i = 3'd0;
  logic [AW-1:0] target_i = '0;
  logic [AW-1:0] bus_addr_i = '0;
  logic          tos_rd_i = 1'b0;
  logic          tos_wr_i = 1'b0;
  logic [AW-1:0] tos_wdata_i = '0;
  logic [AW-1:0] pc_o;
  logic [AW-1:0] tos_o;
  logic [4:0]    depth_o;
  logic          ovf_o;
  logic          udf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcs_top #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .target_i(target_i),
    .bus_addr_i(bus_addr_i), .tos_rd_i(tos_rd_i), .tos_wr_i(tos_wr_i),
    .tos_wdata_i(tos_wdata_i), .pc_o(pc_o), .tos_o(tos_o),
    .depth_o(depth_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, sample 1 ns later
  task automatic step(input logic [2:0] c, input logic [AW-1:0] t,
                      input logic [AW-1:0] b, input logic rd, input logic wr,
                      input logic [AW-1:0] wd);
    @(negedge clk);
    cmd_i = c; target_i = t; bus_addr_i = b;
    tos_rd_i = rd; tos_wr_i = wr; tos_wdata_i = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_i = 3'd0; tos_rd_i = 1'b0; tos_wr_i = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 pc", int'(pc_o), 0);
    chk("R1 depth", int'(depth_o), 0);
    chk("R1 flags", int'({ovf_o, udf_o}), 0);
    chk("R1 tos", int'(tos_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[79:77], v[76:63], v[62:49], v[48], v[47], v[46:33]);
      chk($sformatf("R2-7 vec%0d pc", i), int'(pc_o), int'(v[32:19]));
      chk($sformatf("R8 vec%0d depth", i), int'(depth_o), int'(v[18:14]));
      chk($sformatf("R8 vec%0d tos", i), int'(tos_o), int'(v[13:0]));
    end

    // R2 wrap at the top address
    step(3'd1, 14'h3FFF, '0, 1'b0, 1'b0, '0);
    step(3'd0, '0, '0, 1'b0, 1'b0, '0);
    chk("R2 wrap", int'(pc_o), 0);

    // R10 return on empty stack
    chk("R10 udf before", int'(udf_o), 0);
    step(3'd1, 14'h0444, '0, 1'b0, 1'b0, '0);
    step(3'd2, '0, '0, 1'b0, 1'b0, '0);
    chk("R10 pc to zero", int'(pc_o), 0);
    chk("R10 depth", int'(depth_o), 0);
    chk("R10 udf", int'(udf_o), 1);

    // R11 pop and push together on an empty stack: loop entry plus side read
    step(3'd5, '0, '0, 1'b1, 1'b0, '0);
    chk("R11 empty depth", int'(depth_o), 1);
    chk("R11 empty tos", int'(tos_o), 1);

    // R11 on a non-empty stack, and R8 read value seen before the pop edge
    step(3'd0, '0, '0, 1'b0, 1'b1, 14'h0011);
    @(negedge clk);
    cmd_i = 3'd4; target_i = 14'h0300; tos_rd_i = 1'b1; tos_wr_i = 1'b0;
    chk("R8 read data", int'(tos_o), 16'h0011);
    @(posedge clk);
    #1;
    chk("R11 depth kept", int'(depth_o), 2);
    chk("R11 top replaced", int'(tos_o), 3);
    chk("R4 call pc", int'(pc_o), 16'h0300);

    // R9 overflow after a fresh reset
    do_reset();
    for (int k = 0; k < DEPTH; k++) step(3'd5, '0, '0, 1'b0, 1'b0, '0);
    chk("R9 full depth", int'(depth_o), DEPTH);
    chk("R9 no ovf yet", int'(ovf_o), 0);
    chk("R1 udf cleared", int'(udf_o), 0);
    step(3'd4, 14'h0222, '0, 1'b0, 1'b0, '0);
    chk("R9 pc", int'(pc_o), 16'h0222);
    chk("R9 depth unchanged", int'(depth_o), DEPTH);
    chk("R9 tos unchanged", int'(tos_o), DEPTH);
    chk("R9 ovf", int'(ovf_o), 1);

    // R11 at full: return plus side write replaces the top
    step(3'd2, '0, '0, 1'b0, 1'b1, 14'h0999);
    chk("R11 full pc", int'(pc_o), DEPTH);
    chk("R11 full depth", int'(depth_o), DEPTH);
    chk("R11 full tos", int'(tos_o), 16'h0999);

    step(3'd7, '0, '0, 1'b0, 1'b0, '0);
    chk("R9 ovf sticky", int'(ovf_o), 1);
    chk("R7 discard depth", int'(depth_o), DEPTH - 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule